// File: doc/BRIEF.md
# Multiplex-Aware Display Memory Loader

This block turns a stream of display bytes into single-word writes on a segment memory of 160 words by 4 bits. Each word is one segment column, and bit k of a word is the pixel for backplane k. The grouping of incoming bits depends on the multiplex setting. With one backplane, each bit fills its own column. With two backplanes, bits are taken in pairs. With three, they are taken in triples. With four, they are taken in nibbles.

A column that a byte leaves partly filled in three-backplane operation is finished by the first bits of the next byte. Two registers set the write position: a column pointer and a 3-bit cascade slot counter. Both are loaded by strobes from the command side. The pointer advances by one after each column is completed. When it runs past the last column, it returns to zero and the slot counter steps. This lets one byte stream fill a chain of devices, even when the hand-over falls inside a byte.

A device writes its memory only while the slot counter equals its two strap pins. A device that does not match still follows the pointer and the counter. In the one- and two-backplane settings, a bank input moves the writes to the upper two rows.

The block accepts a byte strobe and then spends one clock per group on the write port. One byte therefore takes two to eight cycles.

Top module: `disp_ram_loader`

## Requirements
- R1: After reset the pointer, the slot counter and the column fill position are all zero, no write is in progress, and `wr_en` is low.
- R2: In mode 0 (one backplane), the eight bits of a byte go to eight consecutive columns, most significant bit first, each bit in row 0, with `wr_mask` = 4'b0001.
- R3: In mode 1 (two backplanes), a byte fills four columns with bit pairs. The earlier bit of each pair is written to row 0 and the later bit to row 1.
- R4: In mode 2 (three backplanes), rows 0..2 of each column are filled in order. A byte covers two full columns plus part of a third. The remaining rows of that column are filled by the next byte before the pointer moves on, so three bytes fill exactly eight columns.
- R5: In mode 3 (four backplanes), a byte fills two full columns. The upper nibble goes to the first column, with bit 7 in row 0, and the lower nibble goes to the second column.
- R6: The pointer advances by one each time a column's last row is written. It does not advance for a partial column.
- R7: Completing column 159 sets the pointer to 0 and increments the slot counter, which wraps from 7 to 0. This can happen in the middle of a byte.
- R8: `wr_en` is raised only while the slot counter equals {1'b0, `dev_addr`}. A non-matching device still advances its pointer and slot counter exactly as a matching one does.
- R9: With `bank_sel` high in modes 0 and 1, writes move up by two rows (row 0 becomes row 2, row 1 becomes row 3). In modes 2 and 3, `bank_sel` has no effect.
- R10: `ptr_load` and `sub_load` take effect at the next clock edge. They abort any groups of the current byte not yet written and clear the fill position.
- R11: A `byte_valid` strobe that arrives while an earlier byte is still being written is ignored.
- R12: Each write asserts at least one mask bit, and `wr_data` is zero outside the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| byte_valid | input | 1 | one-cycle strobe: `byte_in` holds a display byte |
| byte_in | input | 8 | display byte |
| ptr_load | input | 1 | load the column pointer from `ptr_value` |
| ptr_value | input | 8 | new pointer value (0..159) |
| sub_load | input | 1 | load the slot counter from `sub_value` |
| sub_value | input | 3 | new slot counter value |
| mode | input | 2 | backplanes minus one: 0..3 |
| bank_sel | input | 1 | upper-row bank for modes 0 and 1 |
| dev_addr | input | 2 | strap pins giving this device's slot |
| wr_en | output | 1 | memory write strobe |
| wr_addr | output | 8 | column being written |
| wr_data | output | 4 | row bits for the column |
| wr_mask | output | 4 | rows actually written |

## Verification
A wrong pointer or fill position does not stay hidden. It shows up as a wrong `wr_addr`, or as a shifted `wr_mask` or `wr_data`, on the very next group the block writes. A wrong slot counter shows up as writes that are missing or unexpected. This appears only when the stream next crosses a device boundary, so the bench drives long streams across column 159 and through the counter's wrap from 7 to 0. Every write is compared in the cycle it appears against an independent bit-by-bit model of the column filling.

// File: rtl/disp_ram_loader.sv
module disp_ram_loader #(
  parameter int COLS = 160,
  parameter int AW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_valid,
  input  logic [7:0]    byte_in,
  input  logic          ptr_load,
  input  logic [AW-1:0] ptr_value,
  input  logic          sub_load,
  input  logic [2:0]    sub_value,
  input  logic [1:0]    mode,
  input  logic          bank_sel,
  input  logic [1:0]    dev_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [3:0]    wr_data,
  output logic [3:0]    wr_mask
);
  localparam logic [AW-1:0] LAST = AW'(COLS - 1);

  logic [AW-1:0] ptr;
  logic [2:0]    sub;
  logic [1:0]    row;
  logic [7:0]    sh;
  logic [3:0]    left;
  logic          busy;

  logic [2:0] gsz, avail, take;
  logic [3:0] raw_m, raw_d;
  logic       col_done, hi_bank;

  assign gsz      = {1'b0, mode} + 3'd1;
  assign avail    = gsz - {1'b0, row};
  assign take     = (left < {1'b0, avail}) ? left[2:0] : avail;
  assign col_done = ({1'b0, row} + take) == gsz;
  assign hi_bank  = bank_sel && !mode[1];

  always_comb begin
    raw_m = '0;
    raw_d = '0;
    for (int k = 0; k < 4; k++) begin
      if (k >= int'(row) && k < int'(row) + int'(take)) begin
        raw_m[k] = 1'b1;
        raw_d[k] = sh[7 - (k - int'(row))];
      end
    end
  end

  assign wr_en   = busy && (sub == {1'b0, dev_addr});
  assign wr_addr = ptr;
  assign wr_mask = wr_en ? (hi_bank ? {raw_m[1:0], 2'b00} : raw_m) : 4'b0000;
  assign wr_data = wr_en ? (hi_bank ? {raw_d[1:0], 2'b00} : raw_d) : 4'b0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      sub  <= '0;
      row  <= '0;
      sh   <= '0;
      left <= '0;
      busy <= 1'b0;
    end else if (ptr_load || sub_load) begin
      if (ptr_load) ptr <= ptr_value;
      if (sub_load) sub <= sub_value;
      row  <= '0;
      busy <= 1'b0;
      left <= '0;
    end else if (busy) begin
      sh   <= sh << take;
      left <= left - {1'b0, take};
      busy <= left != {1'b0, take};
      if (col_done) begin
        row <= '0;
        if (ptr == LAST) begin
          ptr <= '0;
          sub <= sub + 3'd1;
        end else begin
          ptr <= ptr + AW'(1);
        end
      end else begin
        row <= row + take[1:0];
      end
    end else if (byte_valid) begin
      busy <= 1'b1;
      sh   <= byte_in;
      left <= 4'd8;
    end
  end
endmodule

// File: rtl/disp_ram_loader_chk.sv
module disp_ram_loader_chk #(
  parameter int COLS = 160,
  parameter int AW   = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ptr_load,
  input logic          sub_load,
  input logic [1:0]    mode,
  input logic          bank_sel,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [3:0]    wr_data,
  input logic [3:0]    wr_mask
);
  assert_mask_nonzero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_mask != 4'b0000);
  assert_data_in_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data & ~wr_mask) == 4'b0000);
  assert_single_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode == 2'd0) |-> $countones(wr_mask) == 1);
  assert_full_nibble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode == 2'd3) |-> wr_mask == 4'hF);
  assert_bank_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bank_sel && !mode[1]) |-> wr_mask[1:0] == 2'b00);
  assert_load_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_load || sub_load) |=> !wr_en);
  assert_addr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> int'(wr_addr) < COLS);
endmodule

bind disp_ram_loader disp_ram_loader_chk #(.COLS(COLS), .AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .sub_load(sub_load),
  .mode(mode), .bank_sel(bank_sel), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_mask(wr_mask)
);

// File: tb/disp_ram_loader_test.sv
module disp_ram_loader_test;
  logic clk = 0, rst_n = 0;
  logic byte_valid = 0, ptr_load = 0, sub_load = 0, bank_sel = 0;
  logic [7:0] byte_in = 0, ptr_value = 0;
  logic [2:0] sub_value = 0;
  logic [1:0] mode = 0, dev_addr = 2'b01;
  logic wr_en;
  logic [7:0] wr_addr;
  logic [3:0] wr_data, wr_mask;

  always #5 clk = ~clk;

  disp_ram_loader uut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
    .ptr_load(ptr_load), .ptr_value(ptr_value), .sub_load(sub_load),
    .sub_value(sub_value), .mode(mode), .bank_sel(bank_sel), .dev_addr(dev_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] qa[$];
  logic [3:0] qd[$], qm[$];
  string qt[$];

  int m_ptr = 0, m_sub = 0, m_row = 0;

  task automatic chk(input bit ok, input string tag, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // Bit-by-bit reference: fills rows of the current column, flushes on column end or byte end.
  task automatic model_byte(input logic [7:0] b, input int keep, input string tag);
    int g = int'(mode) + 1;
    int off = (bank_sel && mode < 2) ? 2 : 0;
    int groups = 0;
    logic [3:0] d = 0, m = 0;
    for (int i = 7; i >= 0; i--) begin
      d[m_row + off] = b[i];
      m[m_row + off] = 1'b1;
      m_row++;
      if (m_row == g || i == 0) begin
        if (groups < keep && m_sub == int'({1'b0, dev_addr})) begin
          qa.push_back(8'(m_ptr)); qd.push_back(d); qm.push_back(m); qt.push_back(tag);
        end
        groups++;
        d = 0; m = 0;
        if (m_row == g) begin
          m_row = 0;
          m_ptr++;
          if (m_ptr == 160) begin m_ptr = 0; m_sub = (m_sub + 1) % 8; end
        end
      end
    end
  endtask

  task automatic set_cfg(input logic [1:0] md, input logic bk);
    @(negedge clk); mode = md; bank_sel = bk;
  endtask

  task automatic load(input int p, input int s);
    @(negedge clk);
    ptr_load = 1; ptr_value = 8'(p); sub_load = 1; sub_value = 3'(s);
    @(negedge clk);
    ptr_load = 0; sub_load = 0;
    m_ptr = p; m_sub = s; m_row = 0;
  endtask

  task automatic send(input logic [7:0] b, input string tag);
    model_byte(b, 99, tag);
    @(negedge clk); byte_valid = 1; byte_in = b;
    @(negedge clk); byte_valid = 0;
    repeat (8) @(negedge clk);
  endtask

  // Monitor: compare each write against the next expected item.
  always @(negedge clk) begin
    #1;
    if (rst_n && wr_en) begin
      if (qa.size() == 0) begin
        chk(0, "R8", $sformatf("unexpected write addr=%0d data=%b mask=%b expected none", wr_addr, wr_data, wr_mask));
      end else begin
        logic [7:0] ea; logic [3:0] ed, em; string t;
        ea = qa.pop_front(); ed = qd.pop_front(); em = qm.pop_front(); t = qt.pop_front();
        chk(wr_addr == ea && wr_data == ed && wr_mask == em, t,
            $sformatf("addr=%0d data=%b mask=%b expected addr=%0d data=%b mask=%b",
                      wr_addr, wr_data, wr_mask, ea, ed, em));
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(wr_en == 0, "R1", $sformatf("wr_en=%b expected 0 in reset", wr_en));
    rst_n = 1;
    @(negedge clk); #1;
    chk(wr_en == 0, "R1", $sformatf("wr_en=%b expected 0 after reset", wr_en));

    // R1, R8: slot 0 after reset does not match dev 1, pointer still moves.
    set_cfg(2'd0, 0);
    send(8'hFF, "R8");
    load(10, 1);
    send(8'hA5, "R2");
    send(8'h3C, "R6");
    set_cfg(2'd1, 0);
    send(8'hB4, "R3");
    set_cfg(2'd1, 1);
    send(8'h6D, "R9");
    set_cfg(2'd0, 1);
    send(8'h81, "R9");
    set_cfg(2'd3, 1);
    send(8'h5A, "R5");
    set_cfg(2'd2, 1);
    send(8'hC3, "R9");
    set_cfg(2'd2, 0);
    load(40, 1);
    send(8'hE1, "R4");
    send(8'h96, "R4");
    send(8'h2F, "R4");
    send(8'hD8, "R6");

    // R7/R8: boundary crossing out of this device's slot.
    set_cfg(2'd3, 0);
    load(158, 1);
    send(8'h7E, "R7");
    send(8'h42, "R8");
    // R7: crossing into this device in the middle of a byte.
    set_cfg(2'd0, 0);
    load(157, 0);
    send(8'hB6, "R7");
    // R7: slot counter wraps 7 -> 0, then 80 bytes reach slot 1.
    set_cfg(2'd3, 0);
    load(159, 7);
    send(8'h11, "R7");
    for (int i = 0; i < 80; i++) send(8'(i * 37 + 5), "R7");
    send(8'hC9, "R7");

    // R10: pointer load in the middle of a byte aborts the rest.
    set_cfg(2'd0, 0);
    load(60, 1);
    model_byte(8'hF0, 2, "R10");
    @(negedge clk); byte_valid = 1; byte_in = 8'hF0;
    @(negedge clk); byte_valid = 0;
    @(negedge clk); ptr_load = 1; ptr_value = 8'd70;
    @(negedge clk); ptr_load = 0;
    m_ptr = 70; m_row = 0;
    repeat (8) @(negedge clk);
    send(8'h99, "R10");

    // R11: a second strobe during a busy byte is ignored.
    model_byte(8'h0F, 99, "R11");
    @(negedge clk); byte_valid = 1; byte_in = 8'h0F;
    @(negedge clk); byte_valid = 0;
    @(negedge clk); byte_valid = 1; byte_in = 8'hFF;
    @(negedge clk); byte_valid = 0;
    repeat (10) @(negedge clk);
    send(8'h55, "R11");

    repeat (4) @(negedge clk);
    chk(qa.size() == 0, "R12", $sformatf("pending expected writes=%0d expected 0", qa.size()));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule